// File: doc/BRIEF.md
# EMS Page Translation Unit

This block maps 16 KB pages of the first megabyte of CPU address space onto physical DRAM pages. It is built for a 386-class chipset. A file of 36 page registers holds physical page numbers. Registers 0 to 11 serve twelve expanded-memory windows in upper memory. Registers 12 to 35 serve twenty-four backfill windows that replace conventional memory from 256 KB to 640 KB. When an access falls in an enabled window, the output address is the register's page number followed by the 14 offset bits. When it does not, the CPU address passes through unchanged.

Software programs the unit through a small byte-wide I/O interface with five port codes:
- Index port (code 0): bits 5:0 select a register and bit 6 turns on auto-increment.
- Data port (code 1): reads and writes the selected register, low byte first, then high byte.
- Two configuration ports (codes 2 and 3).
- Slot-boundary port (code 4).

A two-state byte-phase machine steers data-port accesses. Its states are PH_LOW and PH_HIGH, with three transitions:
- An index-port write always returns it to PH_LOW.
- A data-port access in PH_LOW moves it to PH_HIGH.
- A data-port access in PH_HIGH returns it to PH_LOW. If auto-increment is set, this access also advances the index.

Top module: `ems_page_mapper`

## Requirements
- R1: After reset, register i holds page number 48+i for i<12 and i+4 for 12≤i<36. Both configuration bytes, the index and auto-increment are zero, and the phase is PH_LOW.
- R2: A write to port code 0 loads the index from bits 5:0 and auto-increment from bit 6, and forces PH_LOW. A read of port 0 returns {0, auto-increment, index}.
- R3: Port code 1 works on the selected register, low byte (bits 7:0) in PH_LOW and high byte in PH_HIGH. For the high byte, written bits above the page-number width are dropped and read back as zero. Reads and writes both toggle the phase.
- R4: With auto-increment set, a data access in PH_HIGH advances the index, and index 35 (or any higher value) wraps to 0. Without auto-increment the index is unchanged.
- R5: An index of 36 or more selects no register: data writes change nothing and data reads return 0xFF.
- R6: With configuration byte A bit 4 clear, upper window i (i<12) covers CPU page 48+i (0xC0000–0xEFFFF).
- R7: With configuration byte A bit 4 set, upper windows 0..11 cover pages 40,41,42,43,52,53,54,55,44,45,46,47 in that order. Pages 48–51 and 56–59 then pass through.
- R8: Upper window i is enabled only when bit i of a 12-bit mask is set. Mask bits 7:0 come from configuration byte B and bits 11:8 from configuration byte A bits 3:0.
- R9: Backfill window j (register 12+j) covers page 16+j, and needs configuration byte A bit 6.
- R10: Configuration byte A bit 7 gates every window. A page with no enabled window outputs the CPU address zero-extended, with the hit flag low.
- R11: A write of 4 to 9 inclusive to port code 4 (boundary in 64 KB units) clears configuration byte A bit 6. Any other value has no effect.
- R12: For a hit, the physical address is {page number, cpu_addr[13:0]}, and the hit flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe (advances data-port phase) |
| io_port | input | 3 | Port code 0..4 |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte for the addressed port (combinational) |
| cpu_addr | input | 20 | CPU address in the first megabyte |
| phys_addr | output | PA_W | Translated physical address |
| ems_hit | output | 1 | Page is served by an enabled window |

## Verification
The bench builds the unit with its default parameters: 12 upper windows, 24 backfill windows and a 24-bit physical address. This gives 10-bit page numbers, so a high-byte write carries two live bits and six dropped bits, and the dropping is observable. With 36 registers behind a 6-bit index, the indices 36 to 63 are reachable and show the ignored-write and 0xFF-read behaviour. Index 35 sits next to them and shows the auto-increment wrap.

// File: rtl/ems_pkg.sv
package ems_pkg;
    localparam int CPU_AW        = 20;
    localparam int PG_SHIFT      = 14;
    localparam int CPU_PG_W      = CPU_AW - PG_SHIFT;
    localparam int IDX_W         = 6;
    localparam int UPPER_BASE_PG = 48;
    localparam int BACK_BASE_PG  = 16;
    localparam int SLOT_CLR_LO   = 4;
    localparam int SLOT_CLR_HI   = 9;

    localparam logic [2:0] PORT_INDEX = 3'd0;
    localparam logic [2:0] PORT_DATA  = 3'd1;
    localparam logic [2:0] PORT_CFG_A = 3'd2;
    localparam logic [2:0] PORT_CFG_B = 3'd3;
    localparam logic [2:0] PORT_SLOT  = 3'd4;

    localparam int CFGA_GLOBAL   = 7;
    localparam int CFGA_BACKFILL = 6;
    localparam int CFGA_ALTMAP   = 4;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } byte_phase_e;

    // Alternate placement of upper window i when the alt-map bit is set.
    function automatic int alt_upper_page(input int i);
        if (i < 4)      return 40 + i;
        else if (i < 8) return 48 + i;
        else            return 36 + i;
    endfunction
endpackage

// File: rtl/ems_port_ctrl.sv
module ems_port_ctrl
    import ems_pkg::*;
#(
    parameter int NUM_REGS = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [2:0]       io_port,
    input  logic [7:0]       io_wdata,
    output logic [IDX_W-1:0] cur_idx,
    output logic             auto_inc,
    output byte_phase_e      phase,
    output logic [7:0]       cfg_a,
    output logic [7:0]       cfg_b,
    output logic             reg_we,
    output logic             reg_hi
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] NREG_IDX = IDX_W'(NUM_REGS);

    logic             idx_load, data_acc, slot_clr;
    byte_phase_e      phase_nxt;
    logic [IDX_W-1:0] idx_nxt;

    assign idx_load = io_wr && (io_port == PORT_INDEX);
    assign data_acc = (io_wr || io_rd) && (io_port == PORT_DATA);
    assign slot_clr = io_wr && (io_port == PORT_SLOT) &&
                      (io_wdata >= 8'(SLOT_CLR_LO)) && (io_wdata <= 8'(SLOT_CLR_HI));

    always_comb begin
        phase_nxt = phase;
        idx_nxt   = cur_idx;
        if (idx_load) begin
            phase_nxt = PH_LOW;
            idx_nxt   = io_wdata[IDX_W-1:0];
        end else if (data_acc) begin
            unique case (phase)
                PH_LOW:  phase_nxt = PH_HIGH;
                PH_HIGH: begin
                    phase_nxt = PH_LOW;
                    if (auto_inc)
                        idx_nxt = (cur_idx >= LAST_IDX) ? '0 : cur_idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_LOW;
            cur_idx  <= '0;
            auto_inc <= 1'b0;
            cfg_a    <= '0;
            cfg_b    <= '0;
        end else begin
            phase   <= phase_nxt;
            cur_idx <= idx_nxt;
            if (idx_load)
                auto_inc <= io_wdata[6];
            if (io_wr && (io_port == PORT_CFG_A))
                cfg_a <= io_wdata;
            else if (slot_clr)
                cfg_a[CFGA_BACKFILL] <= 1'b0;
            if (io_wr && (io_port == PORT_CFG_B))
                cfg_b <= io_wdata;
        end
    end

    always_comb begin
        reg_we = io_wr && (io_port == PORT_DATA) && (cur_idx < NREG_IDX);
        reg_hi = (phase == PH_HIGH);
    end
endmodule

// File: rtl/ems_page_file.sv
module ems_page_file
    import ems_pkg::*;
#(
    parameter int NUM_UPPER = 12,
    parameter int NUM_REGS  = 36,
    parameter int PN_W      = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           hi,
    input  logic [IDX_W-1:0]               widx,
    input  logic [7:0]                     wdata,
    output logic [NUM_REGS-1:0][PN_W-1:0]  pages
);
    localparam int HI_W = PN_W - 8;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int RST_PG = (g < NUM_UPPER) ? (UPPER_BASE_PG + g)
                                                : (BACK_BASE_PG + g - NUM_UPPER);
        logic [PN_W-1:0] pg_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                pg_q <= PN_W'(RST_PG);
            else if (we && (widx == IDX_W'(g))) begin
                if (hi) pg_q[PN_W-1:8] <= wdata[HI_W-1:0];
                else    pg_q[7:0]      <= wdata;
            end
        end
        assign pages[g] = pg_q;
    end
endmodule

// File: rtl/ems_xlate.sv
module ems_xlate
    import ems_pkg::*;
#(
    parameter int NUM_UPPER = 12,
    parameter int NUM_REGS  = 36,
    parameter int PN_W      = 10,
    parameter int PA_W      = 24
) (
    input  logic [CPU_AW-1:0]              cpu_addr,
    input  logic [NUM_REGS-1:0][PN_W-1:0]  pages,
    input  logic                           glob_en,
    input  logic                           back_en,
    input  logic                           alt_map,
    input  logic [NUM_UPPER-1:0]           upper_mask,
    output logic [PA_W-1:0]                phys_addr,
    output logic                           ems_hit
);
    logic [CPU_PG_W-1:0] cpu_pg;
    logic [NUM_REGS-1:0] match;
    logic [PN_W-1:0]     sel_pn;

    assign cpu_pg = cpu_addr[CPU_AW-1:PG_SHIFT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_win
        if (g < NUM_UPPER) begin : g_up
            localparam logic [CPU_PG_W-1:0] PG_N = CPU_PG_W'(UPPER_BASE_PG + g);
            localparam logic [CPU_PG_W-1:0] PG_A = CPU_PG_W'(alt_upper_page(g));
            assign match[g] = glob_en && upper_mask[g] &&
                              (cpu_pg == (alt_map ? PG_A : PG_N));
        end else begin : g_bf
            localparam logic [CPU_PG_W-1:0] PG_B = CPU_PG_W'(BACK_BASE_PG + g - NUM_UPPER);
            assign match[g] = glob_en && back_en && (cpu_pg == PG_B);
        end
    end

    always_comb begin
        sel_pn = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (match[i]) sel_pn = sel_pn | pages[i];
    end

    assign ems_hit   = |match;
    assign phys_addr = ems_hit ? {sel_pn, cpu_addr[PG_SHIFT-1:0]} : PA_W'(cpu_addr);
endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper
    import ems_pkg::*;
#(
    parameter int NUM_UPPER = 12,
    parameter int NUM_BACK  = 24,
    parameter int PA_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [2:0]        io_port,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [19:0]       cpu_addr,
    output logic [PA_W-1:0]   phys_addr,
    output logic              ems_hit
);
    localparam int NUM_REGS = NUM_UPPER + NUM_BACK;
    localparam int PN_W     = PA_W - PG_SHIFT;

    logic [IDX_W-1:0]              cur_idx, rd_idx;
    logic                          auto_inc, reg_we, reg_hi, phase_hi;
    byte_phase_e                   phase;
    logic [7:0]                    cfg_a, cfg_b;
    logic [NUM_REGS-1:0][PN_W-1:0] pages;
    logic [NUM_UPPER-1:0]          upper_mask;
    logic [15:0]                   rd_pg;
    logic                          idx_ok;

    ems_port_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_port(io_port), .io_wdata(io_wdata), .cur_idx(cur_idx),
        .auto_inc(auto_inc), .phase(phase), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .reg_we(reg_we), .reg_hi(reg_hi)
    );

    ems_page_file #(.NUM_UPPER(NUM_UPPER), .NUM_REGS(NUM_REGS), .PN_W(PN_W)) u_file (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .hi(reg_hi),
        .widx(cur_idx), .wdata(io_wdata), .pages(pages)
    );

    assign upper_mask = NUM_UPPER'({cfg_a[3:0], cfg_b});

    ems_xlate #(.NUM_UPPER(NUM_UPPER), .NUM_REGS(NUM_REGS), .PN_W(PN_W), .PA_W(PA_W)) u_xlate (
        .cpu_addr(cpu_addr), .pages(pages),
        .glob_en(cfg_a[CFGA_GLOBAL]), .back_en(cfg_a[CFGA_BACKFILL]),
        .alt_map(cfg_a[CFGA_ALTMAP]), .upper_mask(upper_mask),
        .phys_addr(phys_addr), .ems_hit(ems_hit)
    );

    assign phase_hi = (phase == PH_HIGH);
    assign idx_ok   = cur_idx < IDX_W'(NUM_REGS);
    assign rd_idx   = idx_ok ? cur_idx : '0;
    assign rd_pg    = 16'(pages[rd_idx]);

    always_comb begin
        unique case (io_port)
            PORT_INDEX: io_rdata = {1'b0, auto_inc, cur_idx};
            PORT_DATA:  io_rdata = !idx_ok ? 8'hFF : (phase_hi ? rd_pg[15:8] : rd_pg[7:0]);
            PORT_CFG_A: io_rdata = cfg_a;
            PORT_CFG_B: io_rdata = cfg_b;
            default:    io_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/ems_page_mapper_chk.sv
module ems_page_mapper_chk
    import ems_pkg::*;
#(
    parameter int PA_W     = 24,
    parameter int NUM_REGS = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_wr,
    input logic             io_rd,
    input logic [2:0]       io_port,
    input logic [7:0]       io_wdata,
    input logic [19:0]      cpu_addr,
    input logic [PA_W-1:0]  phys_addr,
    input logic             ems_hit,
    input logic [IDX_W-1:0] cur_idx,
    input logic             auto_inc,
    input logic             phase_hi,
    input logic [7:0]       cfg_a
);
    logic [CPU_PG_W-1:0] pg;
    assign pg = cpu_addr[19:14];

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_port == PORT_INDEX |=>
        cur_idx == $past(io_wdata[5:0]) && auto_inc == $past(io_wdata[6]) && !phase_hi);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) && io_port == PORT_DATA && phase_hi && auto_inc &&
        cur_idx == IDX_W'(NUM_REGS - 1) |=> cur_idx == '0);

    assert_no_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) && io_port == PORT_DATA && !auto_inc |=> $stable(cur_idx));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ems_hit |-> phys_addr == PA_W'(cpu_addr));

    assert_global_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ems_hit |-> cfg_a[CFGA_GLOBAL]);

    assert_backfill_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ems_hit && pg >= 6'd16 && pg <= 6'd39 |-> cfg_a[CFGA_BACKFILL]);

    assert_slot_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_port == PORT_SLOT && io_wdata >= 8'd4 && io_wdata <= 8'd9 |=>
        !cfg_a[CFGA_BACKFILL]);

    assert_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ems_hit |-> phys_addr[13:0] == cpu_addr[13:0]);
endmodule

bind ems_page_mapper ems_page_mapper_chk #(.PA_W(PA_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .ems_hit(ems_hit), .cur_idx(cur_idx), .auto_inc(auto_inc),
    .phase_hi(phase_hi), .cfg_a(cfg_a)
);

// File: tb/ems_page_mapper_bench.sv
module ems_page_mapper_bench;
    localparam int NREG = 36;
    localparam int PNW  = 10;
    localparam int PAW  = 24;
    localparam int ALT_PG [12] = '{40, 41, 42, 43, 52, 53, 54, 55, 44, 45, 46, 47};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [2:0] io_port = 3'd0;
    logic [7:0] io_wdata = 8'd0;
    logic [7:0] io_rdata;
    logic [19:0] cpu_addr = 20'd0;
    logic [PAW-1:0] phys_addr;
    logic ems_hit;

    int n_checks = 0;
    int n_errors = 0;

    logic [PNW-1:0] m_pg [NREG];
    logic [7:0] m_a, m_b;
    logic [5:0] m_idx;
    logic m_ai, m_ph;

    always #10 clk = ~clk;

    ems_page_mapper u_ems_page_mapper (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .ems_hit(ems_hit)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) m_pg[i] = (i < 12) ? PNW'(48 + i) : PNW'(i + 4);
        m_a = 0; m_b = 0; m_idx = 0; m_ai = 0; m_ph = 0;
    endtask

    task automatic model_data(input logic is_wr, input logic [7:0] d);
        if (is_wr && m_idx < NREG) begin
            if (m_ph) m_pg[m_idx][PNW-1:8] = d[PNW-9:0];
            else      m_pg[m_idx][7:0] = d;
        end
        if (m_ph && m_ai) m_idx = (m_idx >= NREG - 1) ? 6'd0 : m_idx + 6'd1;
        m_ph = ~m_ph;
    endtask

    task automatic do_wr(input logic [2:0] port, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_wdata = d;
        @(posedge clk);
        #1 io_wr = 1'b0;
        case (port)
            3'd0: begin m_idx = d[5:0]; m_ai = d[6]; m_ph = 0; end
            3'd1: model_data(1'b1, d);
            3'd2: m_a = d;
            3'd3: m_b = d;
            3'd4: if (d >= 4 && d <= 9) m_a[6] = 1'b0;
            default: ;
        endcase
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] port);
        logic [15:0] p;
        case (port)
            3'd0: return {1'b0, m_ai, m_idx};
            3'd1: begin
                if (m_idx >= NREG) return 8'hFF;
                p = 16'(m_pg[m_idx]);
                return m_ph ? p[15:8] : p[7:0];
            end
            3'd2: return m_a;
            3'd3: return m_b;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic do_rd(input logic [2:0] port, input string req);
        @(negedge clk);
        io_port = port;
        #1 chk(req, "read byte", 32'(io_rdata), 32'(exp_rd(port)));
        io_rd = 1'b1;
        @(posedge clk);
        #1 io_rd = 1'b0;
        if (port == 3'd1) model_data(1'b0, 8'd0);
    endtask

    task automatic xlate_chk(input logic [19:0] a, input string req);
        int pg;
        logic [PAW-1:0] ep;
        logic eh;
        pg = int'(a[19:14]);
        ep = PAW'(a);
        eh = 1'b0;
        if (m_a[7]) begin
            for (int i = 0; i < NREG; i++) begin
                int tp;
                logic on;
                if (i < 12) begin
                    tp = m_a[4] ? ALT_PG[i] : 48 + i;
                    on = (i < 8) ? m_b[i] : m_a[i - 8];
                end else begin
                    tp = i + 4;
                    on = m_a[6];
                end
                if (on && tp == pg) begin
                    eh = 1'b1;
                    ep = {m_pg[i], a[13:0]};
                end
            end
        end
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, "phys_addr", 32'(phys_addr), 32'(ep));
        chk(req, "ems_hit", 32'(ems_hit), 32'(eh));
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state and register defaults read through the data port
        do_rd(3'd0, "R1");
        do_rd(3'd2, "R1");
        do_rd(3'd3, "R1");
        xlate_chk(20'hC0000, "R1");
        do_wr(3'd0, 8'h40);
        for (int i = 0; i < 2 * NREG; i++) do_rd(3'd1, "R1");

        // R2: index port load and readback
        do_wr(3'd0, 8'hC5);
        do_rd(3'd0, "R2");
        // R3: two-byte write, dropped upper bits
        do_wr(3'd0, 8'h05);
        do_wr(3'd1, 8'hAB);
        do_wr(3'd1, 8'hFF);
        do_rd(3'd1, "R3");
        do_rd(3'd1, "R3");
        // R4: wrap at 35 and no advance without auto-increment
        do_wr(3'd0, 8'h63);
        do_wr(3'd1, 8'h12);
        do_wr(3'd1, 8'h01);
        do_rd(3'd0, "R4");
        do_wr(3'd0, 8'h03);
        do_wr(3'd1, 8'h34);
        do_wr(3'd1, 8'h00);
        do_rd(3'd0, "R4");
        // R5: out-of-range index
        do_wr(3'd0, 8'h28);
        do_wr(3'd1, 8'h55);
        do_rd(3'd1, "R5");
        do_rd(3'd1, "R5");
        do_wr(3'd0, 8'h40);
        for (int i = 0; i < 2 * NREG; i++) do_rd(3'd1, "R5");

        // R6 / R12: normal upper windows
        do_wr(3'd0, 8'h00);
        do_wr(3'd1, 8'h7D);
        do_wr(3'd1, 8'h02);
        do_wr(3'd2, 8'h80);
        do_wr(3'd3, 8'h01);
        xlate_chk(20'hC0123, "R6");
        xlate_chk(20'hC4000, "R6");
        xlate_chk(20'hC3FFF, "R12");
        // R7: alternate placement
        do_wr(3'd2, 8'h9F);
        do_wr(3'd3, 8'hFF);
        xlate_chk(20'hA0010, "R7");
        xlate_chk(20'hD0000, "R7");
        xlate_chk(20'hB2222, "R7");
        xlate_chk(20'hC0000, "R7");
        xlate_chk(20'hE0000, "R7");
        // R8: mask high nibble from byte A
        do_wr(3'd2, 8'h88);
        do_wr(3'd3, 8'h00);
        xlate_chk(20'hEC000, "R8");
        xlate_chk(20'hC0000, "R8");
        // R9: backfill gate
        do_wr(3'd2, 8'h80);
        xlate_chk(20'h40000, "R9");
        do_wr(3'd2, 8'hC0);
        xlate_chk(20'h40000, "R9");
        xlate_chk(20'h9FFFF, "R9");
        xlate_chk(20'h3FFFF, "R9");
        // R10: global gate off
        do_wr(3'd2, 8'h4F);
        do_wr(3'd3, 8'hFF);
        xlate_chk(20'hC8000, "R10");
        xlate_chk(20'h50000, "R10");
        // R11: slot boundary clearing
        do_wr(3'd2, 8'hC0);
        do_wr(3'd4, 8'h03);
        xlate_chk(20'h44000, "R11");
        do_wr(3'd4, 8'h0A);
        do_rd(3'd2, "R11");
        do_wr(3'd4, 8'h04);
        xlate_chk(20'h44000, "R11");
        do_rd(3'd2, "R11");
        do_wr(3'd2, 8'hC0);
        do_wr(3'd4, 8'h09);
        do_rd(3'd2, "R11");

        // Random mix covering R2-R12
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0:       do_wr(3'd0, 8'($urandom));
                1, 2:    do_wr(3'd1, 8'($urandom));
                3:       do_wr(3'd2, 8'($urandom));
                4:       do_wr(3'd3, 8'($urandom));
                5:       do_wr(3'd4, 8'($urandom_range(0, 15)));
                6:       do_rd(3'($urandom_range(0, 7)), "R3");
                default: ;
            endcase
            xlate_chk(20'($urandom), "R12");
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule